// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block collects 96 level-sensitive interrupt request lines into three 32-bit banks and turns them into two processor-facing requests: a normal interrupt and a fast interrupt. Each bank has a mask register that blocks sources and a select register that sends sources to the fast path. A vector register reports the byte offset of the lowest-numbered source that is both pending and unmasked, so a handler can index a jump table straight away.

Software reaches the block through a small word-addressed register port. Writes take effect at the clock edge where the write strobe is high. Reads are combinational on the address. The IRQ pending banks only reflect the input levels. The FIQ pending banks latch fast-path hits until software clears them. Three scalar registers hold a table base address, a protect word and an NMI-control word for software.

Top module: `lvl_vic`

## Requirements
- R1: At every clock edge each IRQ pending bit loads its input line's level. Bit i of bank b is source 32*b+i, and the bank is read at word address b (0 to 2).
- R2: `irq_o` is registered. One clock after the inputs and mask settle, it is high exactly when some pending source has its mask bit at 0.
- R3: `fiq_o` is registered like `irq_o`. It is high exactly when some source is pending, unmasked and has its select bit at 1.
- R4: The vector register reads (lowest index n among pending unmasked sources) times 4. Lower banks win over higher banks. The value is 0 when no such source exists. It is registered with the same one-clock latency as `irq_o`.
- R5: Writes to IRQ pending words 0 to 2 leave the pending state and the outputs unchanged.
- R6: FIQ pending words 4 to 6 set a bit while its source is pending, unmasked and selected. The bit stays set after the source goes away. Writing 1 to a bit clears it, but setting wins over clearing in the same cycle.
- R7: The vector register (word 16) is read-only. Writes to it are ignored.
- R8: The base word (17) stores the written value with bits 1:0 forced to 0. The protect word (18) and NMI-control word (19) store all 32 written bits.
- R9: Select words 8 to 10 and mask words 12 to 14 are read/write and reset to 0. A mask bit of 1 blocks its source. A select bit of 1 routes it to the fast path.
- R10: Reads of unmapped word addresses (3, 7, 11, 15, 20 to 63) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 96 | Level-sensitive source lines, bit n is source n |
| reg_word_addr | input | 6 | Register word address (byte offset / 4) |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_word_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench sweeps a single active source across all 96 positions. A vector encoder that scanned from the top, or that used bank-local indices, would report the wrong offset at bank edges 31/32 and 63/64. Pairs of sources and growing masks test the lowest-wins rule. A design that let a higher bank win, or that ignored the mask in the encoder, would leave the vector at a masked source. Writes to read-only pending and vector words are followed by readback, to catch a design that clears pending state on write. The FIQ bits are checked for stickiness and for set beating a concurrent clear.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int REG_W  = 32;
    localparam int GRP_W  = 4;
    localparam int BSEL_W = 2;

    typedef enum logic [GRP_W-1:0] {
        GRP_IPEND = 4'h0,
        GRP_FPEND = 4'h1,
        GRP_SEL   = 4'h2,
        GRP_MASK  = 4'h3,
        GRP_MISC  = 4'h4
    } grp_e;

    typedef enum logic [BSEL_W-1:0] {
        MISC_VEC  = 2'd0,
        MISC_BASE = 2'd1,
        MISC_PROT = 2'd2,
        MISC_NMI  = 2'd3
    } misc_e;
endpackage

// File: rtl/vic_bank.sv
module vic_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    input  logic         wr_mask_i,
    input  logic         wr_sel_i,
    input  logic         wr_fclr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] sel_o,
    output logic [W-1:0] fpend_o,
    output logic [W-1:0] act_o,
    output logic [W-1:0] fact_o
);
    logic [W-1:0] clr;

    // requests visible at the coming edge: levels against the current mask
    assign act_o  = lines_i & ~mask_o;
    assign fact_o = act_o & sel_o;
    assign clr    = wr_fclr_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o  <= '0;
            mask_o  <= '0;
            sel_o   <= '0;
            fpend_o <= '0;
        end else begin
            pend_o  <= lines_i;
            fpend_o <= (fpend_o & ~clr) | fact_o;
            if (wr_mask_i) mask_o <= wdata_i;
            if (wr_sel_i)  sel_o  <= wdata_i;
        end
    end
endmodule

// File: rtl/vic_vec_enc.sv
module vic_vec_enc #(
    parameter int N    = 96,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    act_i,
    output logic            found_o,
    output logic [IDXW-1:0] idx_o
);
    // scan downward so the last hit written is the lowest index
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/lvl_vic.sv
module lvl_vic
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int WADDR_W   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_lines,
    input  logic [WADDR_W-1:0]          reg_word_addr,
    input  logic                        reg_wr,
    input  logic [BANK_W-1:0]           reg_wdata,
    output logic [BANK_W-1:0]           reg_rdata,
    output logic                        irq_o,
    output logic                        fiq_o
);
    localparam int NSRC = NUM_BANKS * BANK_W;
    localparam int IDXW = $clog2(NSRC);

    logic [GRP_W-1:0]  grp;
    logic [BSEL_W-1:0] bsel;
    logic              bank_ok;

    assign grp     = reg_word_addr[WADDR_W-1:BSEL_W];
    assign bsel    = reg_word_addr[BSEL_W-1:0];
    assign bank_ok = int'(bsel) < NUM_BANKS;

    logic [BANK_W-1:0] pend_a  [NUM_BANKS];
    logic [BANK_W-1:0] mask_a  [NUM_BANKS];
    logic [BANK_W-1:0] sel_a   [NUM_BANKS];
    logic [BANK_W-1:0] fpend_a [NUM_BANKS];
    logic [NSRC-1:0]   act_flat, fact_flat, pend_flat, mask_flat;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vic_bank #(.W(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lines_i   (irq_lines[b*BANK_W +: BANK_W]),
            .wr_mask_i (reg_wr && grp == GRP_MASK  && bsel == BSEL_W'(b)),
            .wr_sel_i  (reg_wr && grp == GRP_SEL   && bsel == BSEL_W'(b)),
            .wr_fclr_i (reg_wr && grp == GRP_FPEND && bsel == BSEL_W'(b)),
            .wdata_i   (reg_wdata),
            .pend_o    (pend_a[b]),
            .mask_o    (mask_a[b]),
            .sel_o     (sel_a[b]),
            .fpend_o   (fpend_a[b]),
            .act_o     (act_flat[b*BANK_W +: BANK_W]),
            .fact_o    (fact_flat[b*BANK_W +: BANK_W])
        );
        assign pend_flat[b*BANK_W +: BANK_W] = pend_a[b];
        assign mask_flat[b*BANK_W +: BANK_W] = mask_a[b];
    end

    logic            found;
    logic [IDXW-1:0] idx;

    vic_vec_enc #(.N(NSRC), .IDXW(IDXW)) u_enc (
        .act_i   (act_flat),
        .found_o (found),
        .idx_o   (idx)
    );

    logic [BANK_W-1:0] vec_q, base_q, prot_q, nmi_q;
    logic              misc_wr;

    assign misc_wr = reg_wr && grp == GRP_MISC;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            fiq_o  <= 1'b0;
            vec_q  <= '0;
            base_q <= '0;
            prot_q <= '0;
            nmi_q  <= '0;
        end else begin
            irq_o <= |act_flat;
            fiq_o <= |fact_flat;
            vec_q <= found ? (BANK_W'(idx) << 2) : '0;
            if (misc_wr && bsel == MISC_BASE) base_q <= reg_wdata & ~BANK_W'(3);
            if (misc_wr && bsel == MISC_PROT) prot_q <= reg_wdata;
            if (misc_wr && bsel == MISC_NMI)  nmi_q  <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (grp)
            GRP_IPEND: if (bank_ok) reg_rdata = pend_a[bsel];
            GRP_FPEND: if (bank_ok) reg_rdata = fpend_a[bsel];
            GRP_SEL:   if (bank_ok) reg_rdata = sel_a[bsel];
            GRP_MASK:  if (bank_ok) reg_rdata = mask_a[bsel];
            GRP_MISC: begin
                unique case (bsel)
                    MISC_VEC:  reg_rdata = vec_q;
                    MISC_BASE: reg_rdata = base_q;
                    MISC_PROT: reg_rdata = prot_q;
                    MISC_NMI:  reg_rdata = nmi_q;
                endcase
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int NSRC = 96,
    parameter int W    = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] irq_lines,
    input logic [NSRC-1:0] pend_flat,
    input logic [NSRC-1:0] mask_flat,
    input logic            irq_o,
    input logic            fiq_o,
    input logic [W-1:0]    vec_q,
    input logic [W-1:0]    base_q
);
    logic valid;

    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= 1'b1;
    end

    p_pend_tracks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pend_flat == $past(irq_lines));

    p_irq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> irq_o == $past(|(irq_lines & ~mask_flat)));

    p_fiq_within_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    p_vec_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_q == '0);

    p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q < W'(NSRC * 4) && vec_q[1:0] == 2'b00);

    p_base_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[1:0] == 2'b00);
endmodule

bind lvl_vic vic_checker #(.NSRC(NUM_BANKS*BANK_W), .W(BANK_W)) u_vic_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .pend_flat (pend_flat),
    .mask_flat (mask_flat),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .vec_q     (vec_q),
    .base_q    (base_q)
);

// File: tb/lvl_vic_tb.sv
module lvl_vic_tb_top;
    localparam int NSRC = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_lines = '0;
    logic [5:0]      reg_word_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq_o, fiq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    lvl_vic dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_lines     (irq_lines),
        .reg_word_addr (reg_word_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq_o         (irq_o),
        .fiq_o         (fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_word_addr = a;
        reg_wdata     = d;
        reg_wr        = 1'b1;
        @(negedge clk);
        reg_wr        = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_word_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive(input logic [NSRC-1:0] v);
        @(negedge clk);
        irq_lines = v;
        settle();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // reset state (R9, R2, R4)
        for (int b = 0; b < 3; b++) begin
            rd(6'(12 + b), d); chk("R9 mask reset", d, 0);
            rd(6'(8 + b), d);  chk("R9 select reset", d, 0);
        end
        rd(16, d); chk("R4 vector reset", d, 0);
        chk("R2 irq reset", {31'b0, irq_o}, 0);
        chk("R3 fiq reset", {31'b0, fiq_o}, 0);

        // single-source sweep over all sources: R1, R2, R4
        for (int n = 0; n < NSRC; n++) begin
            drive(NSRC'(1) << n);
            chk("R2 irq single", {31'b0, irq_o}, 1);
            rd(16, d); chk("R4 vector single", d, 32'(n * 4));
            rd(6'(n / 32), d); chk("R1 pending bank", d, 32'(1) << (n % 32));
        end
        drive('0);
        chk("R2 irq idle", {31'b0, irq_o}, 0);
        rd(16, d); chk("R4 vector idle", d, 0);
        rd(0, d);  chk("R1 pending clears", d, 0);

        // pairs: the lower index wins across banks (R4)
        for (int a = 0; a < NSRC; a += 5) begin
            int c;
            c = NSRC - 1 - a;
            drive((NSRC'(1) << a) | (NSRC'(1) << c));
            rd(16, d); chk("R4 lowest of pair", d, 32'(((a < c) ? a : c) * 4));
        end

        // masks over all-active lines (R9, R2, R4)
        drive('1);
        for (int k = 0; k < 32; k += 3) begin
            wr(12, (k == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - k)));
            settle();
            rd(16, d); chk("R4 masked low bits", d, 32'(k * 4));
        end
        wr(12, 32'hFFFF_FFFF); settle();
        rd(16, d); chk("R4 bank0 masked", d, 32'(32 * 4));
        rd(12, d); chk("R9 mask readback", d, 32'hFFFF_FFFF);
        wr(13, 32'hFFFF_FFFF); settle();
        rd(16, d); chk("R4 banks0-1 masked", d, 32'(64 * 4));
        wr(14, 32'hFFFF_FFFF); settle();
        chk("R2 irq all masked", {31'b0, irq_o}, 0);
        rd(16, d); chk("R4 vector all masked", d, 0);
        rd(1, d); chk("R1 pending under mask", d, 32'hFFFF_FFFF);
        for (int b = 0; b < 3; b++) wr(6'(12 + b), 0);
        drive('0);

        // fast path routing (R3)
        wr(9, 32'h0000_0020); settle();
        rd(9, d); chk("R9 select readback", d, 32'h20);
        drive(NSRC'(1) << 37);
        chk("R3 fiq selected", {31'b0, fiq_o}, 1);
        chk("R2 irq with fiq", {31'b0, irq_o}, 1);
        drive(NSRC'(1) << 36);
        chk("R3 fiq unselected", {31'b0, fiq_o}, 0);
        chk("R2 irq unselected", {31'b0, irq_o}, 1);
        drive(NSRC'(1) << 37);
        wr(13, 32'h20); settle();
        chk("R3 fiq masked", {31'b0, fiq_o}, 0);
        wr(13, 0); settle();

        // FIQ pending sticky and write-one-to-clear (R6)
        rd(5, d); chk("R6 fiq pending set", d, 32'h20);
        wr(5, 32'h20); settle();
        rd(5, d); chk("R6 set wins over clear", d, 32'h20);
        drive('0);
        rd(5, d); chk("R6 sticky after drop", d, 32'h20);
        chk("R3 fiq drops with line", {31'b0, fiq_o}, 0);
        wr(5, 32'h0); settle();
        rd(5, d); chk("R6 zero write keeps", d, 32'h20);
        wr(5, 32'h20); settle();
        rd(5, d); chk("R6 cleared", d, 0);

        // IRQ pending writes ignored (R5)
        drive(NSRC'(1) << 70);
        wr(2, 32'hFFFF_FFFF); settle();
        rd(2, d); chk("R5 pending ignores write", d, 32'h40);
        wr(0, 32'hFFFF_FFFF); settle();
        rd(0, d); chk("R5 pending no set", d, 0);
        chk("R5 irq unchanged", {31'b0, irq_o}, 1);
        rd(16, d); chk("R5 vector unchanged", d, 32'(70 * 4));

        // vector read-only (R7)
        wr(16, 32'h0000_0ABC); settle();
        rd(16, d); chk("R7 vector write ignored", d, 32'(70 * 4));
        drive('0);
        wr(16, 32'h1234_5678); settle();
        rd(16, d); chk("R7 vector idle write ignored", d, 0);

        // scalar registers (R8)
        wr(17, 32'hDEAD_BEEF); settle();
        rd(17, d); chk("R8 base low bits", d, 32'hDEAD_BEEC);
        wr(18, 32'h8000_0003); settle();
        rd(18, d); chk("R8 protect full", d, 32'h8000_0003);
        wr(19, 32'h0000_0007); settle();
        rd(19, d); chk("R8 nmi full", d, 32'h7);

        // unmapped reads (R10)
        drive('1);
        wr(3, 32'hFFFF_FFFF); wr(20, 32'hFFFF_FFFF); settle();
        for (int a = 0; a < 64; a++) begin
            if (a == 3 || a == 7 || a == 11 || a == 15 || a >= 20) begin
                rd(6'(a), d); chk("R10 unmapped zero", d, 0);
            end
        end
        drive('0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule